// File: doc/BRIEF.md
# Branch and Load Hazard Stall/Flush Controller

This block is the hazard control for a five-stage, in-order, single-issue pipeline. Conditional branches are resolved in the decode stage and there is no delay slot. Each cycle the block looks at three things. The first is the source registers of the instruction in decode, together with its branch flag. The second is the destination register and the kind of the instructions sitting in execute and in memory. The third is the branch comparison outcome. From these it decides whether fetch and decode must freeze, whether a bubble goes into execute, and whether the wrong-path fetch must be squashed.

A freeze holds the program counter and the fetch/decode register and clears the controls entering execute. A taken branch with its operands ready does three things in one cycle: it loads the program counter from the branch target, overwrites the fetch/decode register with a no-op, and clears that register's valid bit. A branch whose operand comes from an arithmetic instruction now in memory reads that value through a decode-stage bypass, and the block drives that bypass's select. When a freeze and a redirect are wanted in the same cycle, the freeze wins and the branch is evaluated again later. The block is purely combinational; its clock and reset serve only as the sampling reference for its embedded checks.

Top module: `pipeHazardCtl`

## Requirements
- R1: When no hazard is present and no branch is in decode, pcWrite=1, ifIdWrite=1, ifIdFlush=0, idExBubble=0, pcSelTarget=0 and both bypass selects are 0.
- R2: A load in execute (exRegWrite=1, exIsLoad=1) whose exRd is nonzero and equals a used decode source (idRs with idUsesRs=1, or idRt with idUsesRt=1) gives a stall: pcWrite=0, ifIdWrite=0, idExBubble=1. This holds whether or not decode holds a branch.
- R3: A branch in decode whose used source equals a nonzero exRd written by an arithmetic instruction in execute (exIsLoad=0) stalls in the same way.
- R4: A branch in decode whose used source equals a nonzero memRd written by a load in memory stalls. As a result, a branch behind a load stalls for two consecutive cycles while the load moves from execute to memory.
- R5: Register 0 never causes a stall or a bypass, whatever the stage fields hold.
- R6: A taken branch (idIsBranch=1, branchCondMet=1) with no stall gives pcSelTarget=1, ifIdFlush=1, pcWrite=1 and ifIdWrite=1 in the same cycle.
- R7: A branch that is not taken and not stalled gives pcSelTarget=0 and ifIdFlush=0, and fetch continues sequentially.
- R8: When a stall is present, ifIdFlush=0 and pcSelTarget=0 even if branchCondMet=1.
- R9: A branch in decode that is not stalled, and whose used source equals a nonzero memRd written by an arithmetic instruction in memory, sets brFwdRs (for idRs) or brFwdRt (for idRt) to 1. Otherwise these selects are 0.
- R10: A non-branch instruction in decode never stalls because of an arithmetic instruction in execute or memory, or because of a load in memory.
- R11: A source field whose use flag is 0 is ignored: it causes no stall and no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded checks |
| rstN | input | 1 | Active-low reset; disables the checks |
| idUsesRs | input | 1 | Decode instruction reads its first source |
| idUsesRt | input | 1 | Decode instruction reads its second source |
| idRs | input | REG_W | First source register number in decode |
| idRt | input | REG_W | Second source register number in decode |
| idIsBranch | input | 1 | Decode holds a conditional branch |
| branchCondMet | input | 1 | Branch comparison outcome (1 = taken) |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| exRd | input | REG_W | Execute-stage destination register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| memRd | input | REG_W | Memory-stage destination register |
| pcWrite | output | 1 | Program counter write enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| ifIdFlush | output | 1 | Replace fetch/decode contents with a no-op and clear its valid bit |
| idExBubble | output | 1 | Clear the controls entering execute |
| pcSelTarget | output | 1 | Next PC from branch target (1) or sequential (0) |
| brFwdRs | output | 1 | Decode bypass select for the first branch operand from memory |
| brFwdRt | output | 1 | Decode bypass select for the second branch operand from memory |

## Verification
Directed patterns separate the cases that look alike at the ports. A load in execute stalls a non-branch, but an arithmetic producer in execute stalls only a branch. A load in memory stalls only a branch, while an arithmetic producer in memory leads to a bypass instead. A load ahead of a branch is stepped through execute and then memory, which shows the two-cycle freeze; the branch is then redirected once the load reaches writeback. Register 0 and disabled source fields are matched against producers to show that they are ignored. Taken branches are driven while a stall is present to show that the freeze wins. A long run of random decode and stage fields, drawn from a small register range so that matches are frequent, is then checked every cycle against a behavioural model.

// File: rtl/pipeHazardPkg.sv
package pipeHazardPkg;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic               stall;
    logic               redirect;
    logic [NUM_SRC-1:0] fwd;
  } hazStrobeT;
endpackage

// File: rtl/regMatch.sv
module regMatch #(
  parameter int REG_W = 5
) (
  input  logic             srcUsed,
  input  logic [REG_W-1:0] srcReg,
  input  logic             dstWrite,
  input  logic [REG_W-1:0] dstReg,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = srcUsed && dstWrite && (dstReg != ZERO_REG) && (dstReg == srcReg);
  end
endmodule

// File: rtl/hazardDetect.sv
module hazardDetect
  import pipeHazardPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcUsed,
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcReg,
  input  logic                          idIsBranch,
  input  logic                          branchCondMet,
  input  logic                          exRegWrite,
  input  logic                          exIsLoad,
  input  logic [REG_W-1:0]              exRd,
  input  logic                          memRegWrite,
  input  logic                          memIsLoad,
  input  logic [REG_W-1:0]              memRd,
  output hazStrobeT                     strobes
);
  logic [NUM_SRC-1:0] exHit;
  logic [NUM_SRC-1:0] memHit;
  logic anyExHit, anyMemHit;
  logic loadUse, branchOnEx, branchOnMemLoad, stallNow;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    regMatch #(.REG_W(REG_W)) u_exMatch (
      .srcUsed (srcUsed[s]),
      .srcReg  (srcReg[s]),
      .dstWrite(exRegWrite),
      .dstReg  (exRd),
      .hit     (exHit[s])
    );
    regMatch #(.REG_W(REG_W)) u_memMatch (
      .srcUsed (srcUsed[s]),
      .srcReg  (srcReg[s]),
      .dstWrite(memRegWrite),
      .dstReg  (memRd),
      .hit     (memHit[s])
    );
  end

  always_comb begin
    anyExHit        = |exHit;
    anyMemHit       = |memHit;
    loadUse         = exIsLoad && anyExHit;
    branchOnEx      = idIsBranch && anyExHit;
    branchOnMemLoad = idIsBranch && memIsLoad && anyMemHit;
    stallNow        = loadUse || branchOnEx || branchOnMemLoad;

    strobes.stall    = stallNow;
    strobes.redirect = idIsBranch && branchCondMet && !stallNow;
    for (int s = 0; s < NUM_SRC; s++) begin
      strobes.fwd[s] = idIsBranch && !stallNow && memHit[s];
    end
  end

  AST_ZERO_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0 && memRd == '0) |-> !strobes.stall);  // R5
  AST_PLAIN_NO_MEM_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (!idIsBranch && !(exRegWrite && exIsLoad)) |-> !strobes.stall);  // R10
  AST_BRANCH_LOAD_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (idIsBranch && srcUsed[0] && exRegWrite && exIsLoad && exRd != '0 && exRd == srcReg[0])
      |-> strobes.stall);  // R4
  AST_BYPASS_ONLY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.fwd) |-> (idIsBranch && memRegWrite && !memIsLoad));  // R9
endmodule

// File: rtl/hazardDrive.sv
module hazardDrive
  import pipeHazardPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  hazStrobeT          strobes,
  output logic               pcWrite,
  output logic               ifIdWrite,
  output logic               ifIdFlush,
  output logic               idExBubble,
  output logic               pcSelTarget,
  output logic [NUM_SRC-1:0] brFwd
);
  always_comb begin
    pcWrite     = !strobes.stall;
    ifIdWrite   = !strobes.stall;
    idExBubble  = strobes.stall;
    pcSelTarget = strobes.redirect;
    ifIdFlush   = strobes.redirect;
    brFwd       = strobes.fwd;
  end

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |-> (!pcWrite && !ifIdWrite));  // R2
  AST_STALL_BEATS_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |-> (!ifIdFlush && !pcSelTarget));  // R8
  AST_FLUSH_WITH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ifIdFlush |-> (pcSelTarget && pcWrite && ifIdWrite));  // R6
  AST_BYPASS_NOT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (|brFwd) |-> !idExBubble);  // R9
endmodule

// File: rtl/pipeHazardCtl.sv
module pipeHazardCtl
  import pipeHazardPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idUsesRs,
  input  logic             idUsesRt,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idIsBranch,
  input  logic             branchCondMet,
  input  logic             exRegWrite,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exRd,
  input  logic             memRegWrite,
  input  logic             memIsLoad,
  input  logic [REG_W-1:0] memRd,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             ifIdFlush,
  output logic             idExBubble,
  output logic             pcSelTarget,
  output logic             brFwdRs,
  output logic             brFwdRt
);
  hazStrobeT                     strobes;
  logic [NUM_SRC-1:0]            srcUsed;
  logic [NUM_SRC-1:0][REG_W-1:0] srcReg;
  logic [NUM_SRC-1:0]            brFwd;

  always_comb begin
    srcUsed = {idUsesRt, idUsesRs};
    srcReg  = {idRt, idRs};
    brFwdRs = brFwd[0];
    brFwdRt = brFwd[1];
  end

  hazardDetect #(.REG_W(REG_W)) u_detect (
    .clk          (clk),
    .rstN         (rstN),
    .srcUsed      (srcUsed),
    .srcReg       (srcReg),
    .idIsBranch   (idIsBranch),
    .branchCondMet(branchCondMet),
    .exRegWrite   (exRegWrite),
    .exIsLoad     (exIsLoad),
    .exRd         (exRd),
    .memRegWrite  (memRegWrite),
    .memIsLoad    (memIsLoad),
    .memRd        (memRd),
    .strobes      (strobes)
  );

  hazardDrive u_drive (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pcWrite    (pcWrite),
    .ifIdWrite  (ifIdWrite),
    .ifIdFlush  (ifIdFlush),
    .idExBubble (idExBubble),
    .pcSelTarget(pcSelTarget),
    .brFwd      (brFwd)
  );
endmodule

// File: tb/pipeHazardCtl_bench.sv
module pipeHazardCtl_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idUsesRs = 0, idUsesRt = 0, idIsBranch = 0, branchCondMet = 0;
  logic [REG_W-1:0] idRs = '0, idRt = '0, exRd = '0, memRd = '0;
  logic exRegWrite = 0, exIsLoad = 0, memRegWrite = 0, memIsLoad = 0;
  logic pcWrite, ifIdWrite, ifIdFlush, idExBubble, pcSelTarget, brFwdRs, brFwdRt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pipeHazardCtl #(.REG_W(REG_W)) u_pipeHazardCtl (
    .clk(clk), .rstN(rstN),
    .idUsesRs(idUsesRs), .idUsesRt(idUsesRt), .idRs(idRs), .idRt(idRt),
    .idIsBranch(idIsBranch), .branchCondMet(branchCondMet),
    .exRegWrite(exRegWrite), .exIsLoad(exIsLoad), .exRd(exRd),
    .memRegWrite(memRegWrite), .memIsLoad(memIsLoad), .memRd(memRd),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .ifIdFlush(ifIdFlush),
    .idExBubble(idExBubble), .pcSelTarget(pcSelTarget),
    .brFwdRs(brFwdRs), .brFwdRt(brFwdRt)
  );

  // Behavioural reference: {pcWrite, ifIdWrite, ifIdFlush, idExBubble, pcSelTarget, brFwdRs, brFwdRt}
  function automatic logic [6:0] refModel(output string tag);
    int srcs[2];
    bit used[2];
    bit hold = 0;
    bit fw[2];
    bit taken;
    srcs[0] = int'(idRs); srcs[1] = int'(idRt);
    used[0] = idUsesRs;   used[1] = idUsesRt;
    tag = idIsBranch ? "R7" : "R1";
    foreach (srcs[k]) begin
      fw[k] = 0;
      if (used[k] && srcs[k] != 0) begin
        if (exRegWrite && int'(exRd) == srcs[k]) begin
          if (exIsLoad) begin hold = 1; tag = "R2"; end
          else if (idIsBranch) begin hold = 1; tag = "R3"; end
        end
        if (memRegWrite && int'(memRd) == srcs[k] && idIsBranch) begin
          if (memIsLoad) begin hold = 1; if (tag != "R2" && tag != "R3") tag = "R4"; end
          else fw[k] = 1;
        end
      end
    end
    if (hold) begin
      fw[0] = 0; fw[1] = 0;
      if (idIsBranch && branchCondMet) tag = "R8";
    end else if (fw[0] || fw[1]) tag = "R9";
    taken = idIsBranch && branchCondMet && !hold;
    if (taken) tag = "R6";
    return {!hold, !hold, taken, hold, taken, fw[0], fw[1]};
  endfunction

  task automatic checkNow(input string note);
    logic [6:0] expv, actv;
    string tag;
    expv = refModel(tag);
    actv = {pcWrite, ifIdWrite, ifIdFlush, idExBubble, pcSelTarget, brFwdRs, brFwdRt};
    checks++;
    if (actv !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, note, actv, expv);
    end
  endtask

  task automatic setStages(input bit exW, input bit exL, input int exR,
                           input bit memW, input bit memL, input int memR);
    exRegWrite = exW; exIsLoad = exL; exRd = REG_W'(exR);
    memRegWrite = memW; memIsLoad = memL; memRd = REG_W'(memR);
  endtask

  task automatic setId(input bit uRs, input int rs, input bit uRt, input int rt,
                       input bit br, input bit cond);
    idUsesRs = uRs; idRs = REG_W'(rs); idUsesRt = uRt; idRt = REG_W'(rt);
    idIsBranch = br; branchCondMet = cond;
  endtask

  task automatic step(input string note);
    @(negedge clk);
    #1;
    checkNow(note);
  endtask

  task automatic expectBits(input string req, input logic [6:0] want);
    logic [6:0] actv;
    actv = {pcWrite, ifIdWrite, ifIdFlush, idExBubble, pcSelTarget, brFwdRs, brFwdRt};
    checks++;
    if (actv !== want) begin
      fails++;
      $display("FAIL %s directed: actual %b expected %b", req, actv, want);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step("reset state R1");
    expectBits("R1", 7'b1100000);
    @(negedge clk); rstN = 1'b1;

    // R1: quiet pipeline
    setId(1, 3, 1, 4, 0, 0); setStages(1, 0, 7, 1, 0, 8);
    step("no hazard R1"); expectBits("R1", 7'b1100000);

    // R2: load-use on rt for a non-branch
    setId(1, 3, 1, 4, 0, 0); setStages(1, 1, 4, 0, 0, 0);
    step("load use R2"); expectBits("R2", 7'b0001000);

    // R10: ALU in EX and load in MEM do not stall a non-branch
    setId(1, 3, 1, 4, 0, 0); setStages(1, 0, 3, 1, 1, 4);
    step("plain no stall R10"); expectBits("R10", 7'b1100000);

    // R3: branch on ALU result in EX, even with condition met (R8)
    setId(1, 5, 1, 6, 1, 1); setStages(1, 0, 5, 0, 0, 0);
    step("branch on ex alu R3"); expectBits("R3", 7'b0001000);

    // R4: branch behind a load: two stall cycles then redirect
    setId(1, 9, 1, 2, 1, 1); setStages(1, 1, 9, 0, 0, 0);
    step("branch load in ex R4"); expectBits("R4", 7'b0001000);
    setStages(0, 0, 0, 1, 1, 9);
    step("branch load in mem R4"); expectBits("R4", 7'b0001000);
    setStages(0, 0, 0, 0, 0, 0);
    step("branch after load R6"); expectBits("R6", 7'b1110100);

    // R5: register 0 ignored in every stage
    setId(1, 0, 1, 0, 1, 0); setStages(1, 1, 0, 1, 1, 0);
    step("zero reg R5"); expectBits("R5", 7'b1100000);

    // R7: not taken branch, no hazard
    setId(1, 1, 1, 2, 1, 0); setStages(0, 0, 0, 0, 0, 0);
    step("not taken R7"); expectBits("R7", 7'b1100000);

    // R9: bypass from MEM ALU for each operand
    setId(1, 6, 1, 7, 1, 0); setStages(0, 0, 0, 1, 0, 6);
    step("bypass rs R9"); expectBits("R9", 7'b1100010);
    setStages(0, 0, 0, 1, 0, 7);
    step("bypass rt R9"); expectBits("R9", 7'b1100001);

    // R8: bypass candidate while stalled on EX gives no bypass and no flush
    setId(1, 6, 1, 7, 1, 1); setStages(1, 0, 7, 1, 0, 6);
    step("stall beats flush R8"); expectBits("R8", 7'b0001000);

    // R11: unused fields ignored
    setId(0, 4, 0, 5, 1, 0); setStages(1, 1, 4, 1, 0, 5);
    step("unused fields R11"); expectBits("R11", 7'b1100000);
    setId(0, 4, 0, 5, 0, 0); setStages(1, 1, 5, 0, 0, 0);
    step("unused fields plain R11"); expectBits("R11", 7'b1100000);

    // Random traffic against the behavioural model
    for (int n = 0; n < 3000; n++) begin
      setId(1'($urandom), int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom));
      setStages(1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                1'($urandom), 1'($urandom), int'($urandom_range(0, 3)));
      step("random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule